// File: doc/BRIEF.md
# Store Buffer with Selectable Drain Order and Fence

This block sits between one processor core and a single-ported memory. Stores from the core go into a small buffer and are written to memory later. Loads do not wait behind those stores. A load that hits a buffered address takes its data from the youngest matching entry. A load that misses reads memory straight away.

A mode pin chooses how the buffer drains. In the in-order mode, stores leave the buffer in program order, which gives total store ordering. In the relaxed mode, any entry that is ready may leave first, which gives partial store ordering. An entry is ready when no older buffered store has the same address. A fence pin lets software force every earlier store to finish before any later access is accepted.

Every data flow uses valid/ready:
- A store is taken on a clock edge where `st_valid` and `st_ready` are both high. The core must hold the address and data stable until then.
- Loads follow the same rule with `ld_valid` and `ld_ready`. The response comes back exactly one cycle after the load is taken and cannot be back-pressured.
- The memory accepts a request on an edge where `mem_req` and `mem_gnt` are both high. Read data appears on `mem_rdata` in the cycle after an accepted read.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty. With `mem_gnt` high, `st_ready` and `ld_ready` are high, and `mem_req`, `rsp_valid` and `fence_ack` are low.
- R2: A load whose address matches one or more buffered stores gets the data of the youngest matching store. It is accepted even while `mem_gnt` is low, and `rsp_valid` and `rsp_data` appear in the cycle after it is accepted.
- R3: A load may complete while older stores are still buffered and unwritten. A load that misses the buffer needs the memory port, so its `ld_ready` is low while `mem_gnt` is low. Its response then carries the memory data.
- R4: A store accepted on the same edge as a load is treated as younger than that load. The load does not see the store's data.
- R5: When the buffer holds DEPTH entries (default 8), `st_ready` is low. A store offered in that state is ignored and never reaches memory.
- R6: With `mode_pso` = 0 (in-order), stores are written to memory in the order they were accepted.
- R7: With `mode_pso` = 1 (relaxed), each drain writes the youngest entry that has no older buffered entry with the same address. Stores to the same address therefore still reach memory in program order.
- R8: A load that misses the buffer takes the memory port in the cycle it is accepted (`mem_we` = 0, `mem_addr` = the load address). No store drains in that cycle. A store drains on any cycle in which the port is not used by a load.
- R9: While `fence_req` is high and the buffer is not empty, `st_ready` and `ld_ready` are low. Draining continues during this time.
- R10: `fence_ack` goes high in the first cycle that `fence_req` is high and the buffer is empty. It stays high for as long as both conditions hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pso | input | 1 | Drain order: 0 in-order, 1 relaxed |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be accepted |
| ld_addr | input | AW | Load address |
| rsp_valid | output | 1 | Load response valid, one cycle after the load is accepted |
| rsp_data | output | DW | Load response data |
| fence_req | input | 1 | Fence requested |
| fence_ack | output | 1 | Fence complete (buffer empty) |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 write (drain), 0 read (load) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after an accepted read |

## Verification
The bench holds off the memory grant so that stores stay in the buffer. It then checks several corner cases, each chosen to expose a specific bug:
- Repeated stores to one address: a design that forwarded the oldest match, or that let a same-cycle store win, would return stale or premature data.
- A full buffer with an extra store offered: a design with a wrong full test would lose that store or write it.
- Relaxed draining with a blocked same-address pair: this catches a design that drains in FIFO order anyway, or that lets a younger same-address store overtake.
- A load miss racing a pending drain: this catches a design that gives the port to the drain.
- A fence: this catches an acknowledge that comes a cycle early or late, and accesses that slip past the fence.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    DRAIN_IN_ORDER  = 1'b0,
    DRAIN_ANY_READY = 1'b1
  } drain_mode_e;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_use_e;
endpackage

// File: rtl/sb_entry_queue.sv
// Collapsing age-ordered storage: slot 0 is the oldest entry.
module sb_entry_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  input  logic [IW-1:0]             pop_idx,
  output logic [CW-1:0]             count,
  output logic [DEPTH-1:0]          valid_vec,
  output logic [DEPTH-1:0][AW-1:0]  addr_vec,
  output logic [DEPTH-1:0][DW-1:0]  data_vec
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] ins_pos;

  assign ins_pos = count_q - CW'(pop);
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + CW'(push) - CW'(pop);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift_in;
    logic ins_here;
    assign shift_in    = pop && (i >= int'(pop_idx));
    assign ins_here    = push && (ins_pos == CW'(i));
    assign valid_vec[i] = (CW'(i) < count_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_vec[i] <= '0;
        data_vec[i] <= '0;
      end else if (ins_here) begin
        addr_vec[i] <= push_addr;
        data_vec[i] <= push_data;
      end else if (shift_in) begin
        if (i < DEPTH - 1) begin
          addr_vec[i] <= addr_vec[(i < DEPTH - 1) ? i + 1 : i];
          data_vec[i] <= data_vec[(i < DEPTH - 1) ? i + 1 : i];
        end
      end
    end
  end
endmodule

// File: rtl/sb_fwd_lookup.sv
// Youngest-match search for load forwarding.
module sb_fwd_lookup #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0]          valid_vec,
  input  logic [DEPTH-1:0][AW-1:0]  addr_vec,
  input  logic [DEPTH-1:0][DW-1:0]  data_vec,
  input  logic [AW-1:0]             ld_addr,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = valid_vec[i] && (addr_vec[i] == ld_addr);
  end

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_data = data_vec[i];
      end
    end
  end
endmodule

// File: rtl/sb_drain_pick.sv
// Chooses which entry leaves next, per drain mode.
module sb_drain_pick
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  drain_mode_e               mode,
  input  logic [DEPTH-1:0]          valid_vec,
  input  logic [DEPTH-1:0][AW-1:0]  addr_vec,
  output logic                      any,
  output logic [IW-1:0]             idx
);
  logic [DEPTH-1:0] ready_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ready
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (valid_vec[j] && (addr_vec[j] == addr_vec[i])) blocked = 1'b1;
      end
    end
    assign ready_vec[i] = valid_vec[i] && !blocked;
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    if (mode == DRAIN_IN_ORDER) begin
      any = valid_vec[0];
      idx = '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ready_vec[i]) begin
          any = 1'b1;
          idx = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/sb_port_arb.sv
// Shares the single memory port: a missing load beats a drain.
module sb_port_arb
  import sb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          ld_fire,
  input  logic          ld_hit,
  input  logic [AW-1:0] ld_addr,
  input  logic          drain_any,
  input  logic [AW-1:0] drain_addr,
  input  logic [DW-1:0] drain_data,
  input  logic          mem_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pop
);
  port_use_e use_sel;

  always_comb begin
    if (ld_fire && !ld_hit) use_sel = PORT_LOAD;
    else if (drain_any)     use_sel = PORT_DRAIN;
    else                    use_sel = PORT_IDLE;
  end

  assign mem_req   = (use_sel != PORT_IDLE);
  assign mem_we    = (use_sel == PORT_DRAIN);
  assign mem_addr  = (use_sel == PORT_LOAD) ? ld_addr : drain_addr;
  assign mem_wdata = drain_data;
  assign pop       = (use_sel == PORT_DRAIN) && mem_gnt;
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pso,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          fence_req,
  output logic          fence_ack,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]            q_count;
  logic [DEPTH-1:0]         q_valid;
  logic [DEPTH-1:0][AW-1:0] q_addr;
  logic [DEPTH-1:0][DW-1:0] q_data;
  logic                     fwd_hit;
  logic [DW-1:0]            fwd_data;
  logic                     pick_any;
  logic [IW-1:0]            pick_idx;
  logic                     push, pop, ld_fire;
  logic                     empty, fence_block;
  drain_mode_e              mode;

  logic                     rsp_valid_q, rsp_hit_q;
  logic [DW-1:0]            rsp_fwd_q;

  assign mode        = drain_mode_e'(mode_pso);
  assign empty       = (q_count == '0);
  assign fence_block = fence_req && !empty;
  assign fence_ack   = fence_req && empty;
  assign st_ready    = !fence_block && (q_count != CW'(DEPTH));
  assign ld_ready    = !fence_block && (fwd_hit || mem_gnt);
  assign push        = st_valid && st_ready;
  assign ld_fire     = ld_valid && ld_ready;

  sb_entry_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .pop_idx   (pick_idx),
    .count     (q_count),
    .valid_vec (q_valid),
    .addr_vec  (q_addr),
    .data_vec  (q_data)
  );

  sb_fwd_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fwd_i (
    .valid_vec (q_valid),
    .addr_vec  (q_addr),
    .data_vec  (q_data),
    .ld_addr   (ld_addr),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  sb_drain_pick #(.DEPTH(DEPTH), .AW(AW)) pick_i (
    .mode      (mode),
    .valid_vec (q_valid),
    .addr_vec  (q_addr),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  sb_port_arb #(.AW(AW), .DW(DW)) arb_i (
    .ld_fire    (ld_fire),
    .ld_hit     (fwd_hit),
    .ld_addr    (ld_addr),
    .drain_any  (pick_any),
    .drain_addr (q_addr[pick_idx]),
    .drain_data (q_data[pick_idx]),
    .mem_gnt    (mem_gnt),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pop        (pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_fwd_q   <= '0;
    end else begin
      rsp_valid_q <= ld_fire;
      if (ld_fire) begin
        rsp_hit_q <= fwd_hit;
        rsp_fwd_q <= fwd_data;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_hit_q ? rsp_fwd_q : mem_rdata;
endmodule

// File: rtl/sb_store_buffer_chk.sv
module sb_store_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_pso,
  input logic                     st_ready,
  input logic                     ld_valid,
  input logic                     ld_ready,
  input logic [AW-1:0]            ld_addr,
  input logic                     fence_req,
  input logic                     fence_ack,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic [AW-1:0]            mem_addr,
  input logic                     rsp_valid,
  input logic                     fwd_hit,
  input logic                     push,
  input logic                     pop,
  input logic [IW-1:0]            pop_idx,
  input logic [CW-1:0]            count,
  input logic [DEPTH-1:0]         valid_vec,
  input logic [DEPTH-1:0][AW-1:0] addr_vec
);
  logic older_same;

  always_comb begin
    older_same = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j < int'(pop_idx) && valid_vec[j] && addr_vec[j] == addr_vec[pop_idx])
        older_same = 1'b1;
    end
  end

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !st_ready);

  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) + CW'($past(push)) - CW'($past(pop))));

  // R10
  fence_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ack |-> (fence_req && count == '0));

  // R9
  fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req && count != '0) |-> (!st_ready && !ld_ready));

  // R8
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !fwd_hit) |-> (mem_req && !mem_we && mem_addr == ld_addr));

  // R6
  inorder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !mode_pso) |-> (pop_idx == '0));

  // R7
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !older_same);

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> rsp_valid);
endmodule

bind store_buffer sb_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_pso   (mode_pso),
  .st_ready   (st_ready),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready),
  .ld_addr    (ld_addr),
  .fence_req  (fence_req),
  .fence_ack  (fence_ack),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .rsp_valid  (rsp_valid),
  .fwd_hit    (fwd_hit),
  .push       (push),
  .pop        (pop),
  .pop_idx    (pick_idx),
  .count      (q_count),
  .valid_vec  (q_valid),
  .addr_vec   (q_addr)
);

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_pso;
  logic          st_valid;
  logic          st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          ld_valid;
  logic          ld_ready;
  logic [AW-1:0] ld_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          fence_req;
  logic          fence_ack;
  logic          mem_req;
  logic          mem_gnt;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_buffer #(.DEPTH(8), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_pso(mode_pso),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fence_req(fence_req), .fence_ack(fence_ack),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model with a write log.
  logic [DW-1:0] bmem [256];
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  int            wcnt = 0;

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        bmem[mem_addr[7:0]] <= mem_wdata;
        if (wcnt < 64) begin
          wlog_addr[wcnt] <= mem_addr;
          wlog_data[wcnt] <= mem_wdata;
        end
        wcnt <= wcnt + 1;
      end else begin
        mem_rdata <= bmem[mem_addr[7:0]];
      end
    end
  end

  // kind(1: load with expected data, 0: store) | addr | data
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 16'h0010, 32'h0000_0011},
    {1'b0, 16'h0020, 32'h0000_0022},
    {1'b0, 16'h0010, 32'h0000_0033},
    {1'b1, 16'h0010, 32'h0000_0033},
    {1'b1, 16'h0020, 32'h0000_0022},
    {1'b0, 16'h0020, 32'h0000_0044},
    {1'b1, 16'h0020, 32'h0000_0044},
    {1'b1, 16'h0010, 32'h0000_0033}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a;
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ld_valid = 1'b0;
    @(negedge clk); #1;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " rsp_data"}, rsp_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0; mode_pso = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    ld_valid = 1'b0; ld_addr = '0; fence_req = 1'b0; mem_gnt = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 st_ready", 32'(st_ready), 32'd1);
    check("R1 ld_ready", 32'(ld_ready), 32'd1);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 fence_ack", 32'(fence_ack), 32'd0);

    // R2 forwarding table, memory held off
    mem_gnt = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][48]) do_load(VEC[k][47:32], VEC[k][31:0], "R2 forward");
      else            push_store(VEC[k][47:32], VEC[k][31:0]);
    end
    // R3 loads completed with all stores still buffered
    check("R3 no write yet", wcnt, 0);

    // R4 same-cycle store and load to one address
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0010; st_data = 32'h55;
    ld_valid = 1'b1; ld_addr = 16'h0010;
    @(posedge clk); #1;
    st_valid = 1'b0; ld_valid = 1'b0;
    @(negedge clk); #1;
    check("R4 older data", rsp_data, 32'h33);
    do_load(16'h0010, 32'h55, "R4 later load");

    // R5 fill the buffer to 8 entries
    push_store(16'h0030, 32'h300);
    push_store(16'h0031, 32'h310);
    push_store(16'h0032, 32'h320);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0090; st_data = 32'hDEAD;
    #1;
    check("R5 full stall", 32'(st_ready), 32'd0);
    // R3 miss load blocked without port, hit load allowed
    ld_valid = 1'b1; ld_addr = 16'h0040;
    #1;
    check("R3 miss waits", 32'(ld_ready), 32'd0);
    ld_addr = 16'h0030;
    #1;
    check("R2 hit ready", 32'(ld_ready), 32'd1);
    ld_valid = 1'b0;
    @(posedge clk); #1;
    st_valid = 1'b0;

    // R6 in-order drain
    @(negedge clk); mem_gnt = 1'b1;
    repeat (12) @(negedge clk);
    check("R5 dropped store", wcnt, 8);
    check("R6 w0", {wlog_addr[0], wlog_data[0][15:0]}, {16'h0010, 16'h0011});
    check("R6 w1", {wlog_addr[1], wlog_data[1][15:0]}, {16'h0020, 16'h0022});
    check("R6 w2", {wlog_addr[2], wlog_data[2][15:0]}, {16'h0010, 16'h0033});
    check("R6 w3", {wlog_addr[3], wlog_data[3][15:0]}, {16'h0020, 16'h0044});
    check("R6 w4", {wlog_addr[4], wlog_data[4][15:0]}, {16'h0010, 16'h0055});
    check("R6 w7", {wlog_addr[7], wlog_data[7][15:0]}, {16'h0032, 16'h0320});

    // R8 load miss wins the port
    mem_gnt = 1'b0;
    push_store(16'h0050, 32'h66);
    base = wcnt;
    @(negedge clk);
    mem_gnt = 1'b1; ld_valid = 1'b1; ld_addr = 16'h0060;
    #1;
    check("R8 port read", {31'd0, mem_req && !mem_we}, 32'd1);
    check("R8 port addr", 32'(mem_addr), 32'h60);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    @(negedge clk); #1;
    check("R8 miss data", rsp_data, 32'h0);
    check("R8 no drain with load", wcnt, base);
    @(negedge clk); #1;
    check("R8 drain after", wcnt, base + 1);
    do_load(16'h0050, 32'h66, "R3 memory data");

    // R7 relaxed drain order
    mode_pso = 1'b1; mem_gnt = 1'b0;
    push_store(16'h00A0, 32'hD1);
    push_store(16'h00A1, 32'hD2);
    push_store(16'h00A0, 32'hD3);
    push_store(16'h00A2, 32'hD4);
    base = wcnt;
    @(negedge clk); mem_gnt = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 count", wcnt, base + 4);
    check("R7 first", {wlog_addr[base], wlog_data[base][15:0]}, {16'h00A2, 16'h00D4});
    check("R7 second", {wlog_addr[base+1], wlog_data[base+1][15:0]}, {16'h00A1, 16'h00D2});
    check("R7 third", {wlog_addr[base+2], wlog_data[base+2][15:0]}, {16'h00A0, 16'h00D1});
    check("R7 fourth", {wlog_addr[base+3], wlog_data[base+3][15:0]}, {16'h00A0, 16'h00D3});

    // R9 / R10 fence
    mode_pso = 1'b0; mem_gnt = 1'b0;
    push_store(16'h0070, 32'h1);
    push_store(16'h0071, 32'h2);
    @(negedge clk);
    fence_req = 1'b1; ld_valid = 1'b1; ld_addr = 16'h0070;
    #1;
    check("R10 ack early", 32'(fence_ack), 32'd0);
    check("R9 store held", 32'(st_ready), 32'd0);
    check("R9 load held", 32'(ld_ready), 32'd0);
    ld_valid = 1'b0;
    @(negedge clk); mem_gnt = 1'b1;
    #1;
    check("R10 ack two left", 32'(fence_ack), 32'd0);
    @(negedge clk); #1;
    check("R10 ack one left", 32'(fence_ack), 32'd0);
    @(negedge clk); #1;
    check("R10 ack empty", 32'(fence_ack), 32'd1);
    check("R9 fence writes", bmem[8'h71], 32'h2);
    @(negedge clk); #1;
    check("R10 ack held", 32'(fence_ack), 32'd1);
    fence_req = 1'b0;
    #1;
    check("R10 ack drop", 32'(fence_ack), 32'd0);

    finish_run();
  end
endmodule